// File: doc/BRIEF.md
# Instruction Line-Fill Buffer with Most-Recently-Used Writeback

This block sits beside an instruction cache and holds the single line currently being fetched from memory: four longwords, each with its own valid flag. Fetch lookups are compared against the buffered line, and a lookup can be answered from the buffer as soon as the requested longword has arrived. The buffer does not have to wait for the whole line to land in the cache array.

A single recency flag records whether the buffer or the cache array holds the newer copy of the buffered line's set. The flag is raised when a miss opens a new cacheable line. It is dropped when a lookup reaches the same cache set with a different line address. On the next miss the buffered line is copied into the cache data array, one longword per cycle over four cycles. The copy happens only if all four longwords are present, the flag is still raised, the line was cacheable and the cache is neither locked nor frozen. While the copy runs, the block deasserts `ready`, and the new line only takes over the buffer after the copy finishes. The buffer can also hold non-cacheable lines, so that later fetches hit in it. Such a line is never copied into the array. The cache array and the tag store are outside this block.

Top module: `line_fill_buffer`

## Requirements
- R1: While reset is asserted and right after it, `hitValid` and `arrWrEn` are 0 and `ready` is 1. No lookup hits until a miss has opened a line and longwords have been filled.
- R2: A lookup hits when three conditions hold: its line address (longword address without its two low bits) equals the buffered line, the buffer is in use, and the valid flag of the requested longword (`lookupAddr[1:0]`) is set. `hitData` is then that longword as written by the fill for index `fillWord`. A longword not yet filled, or any other line, does not hit.
- R3: An accepted miss clears all four valid flags. After the miss, the previous line no longer hits, and the new line hits only for longwords filled since the miss.
- R4: An accepted miss copies the line to the array when all of the following hold: all four valid flags are set, the recency flag is set, the line was cacheable, and `lockFreeze` is 0. The copy begins the cycle after the miss. `arrWrEn` is high for exactly four cycles. `arrWrAddr` is the old line's byte address with bits [3:2] equal to 0, 1, 2, 3 in successive cycles and bits [1:0] zero. `arrWrData` is the matching buffered longword.
- R5: A miss with a partially filled buffer causes no array write.
- R6: A lookup whose set index (line-address bits [IDX_W-1:0], i.e. byte-address bits [IDX_W+3:4], with IDX_W = log2 of SETS) equals the buffered line's index but whose line address differs clears the recency flag, so the next miss causes no array write. Lookups to the buffered line itself leave the flag set.
- R7: A miss accepted while `lockFreeze` is 1 causes no array write.
- R8: With `bufNcEn` 1 at the miss, a non-cacheable line is filled and hits, but it is never written to the array. With `bufNcEn` 0, fills to a non-cacheable line are dropped and it never hits.
- R9: `ready` is 0 during the four copy cycles. Fills and misses presented while `ready` is 0 are ignored, and a fill presented in the same cycle as a miss is ignored. The new line takes over the buffer when the copy ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | A cache miss opens a new line |
| missLine | input | ADDR_W-4 | Line address of the miss (byte address bits [ADDR_W-1:4]) |
| missCacheable | input | 1 | The missed line is cacheable |
| lockFreeze | input | 1 | Cache is locked or frozen; blocks the copy to the array |
| bufNcEn | input | 1 | Allow non-cacheable lines to be held in the buffer |
| fillValid | input | 1 | A fetched longword is presented |
| fillWord | input | 2 | Longword index within the line for the fill |
| fillData | input | DATA_W | Fill data |
| ready | output | 1 | Block accepts misses and fills |
| lookupValid | input | 1 | A fetch lookup is presented |
| lookupAddr | input | ADDR_W-2 | Longword address of the lookup |
| hitValid | output | 1 | Lookup hits in the buffer |
| hitData | output | DATA_W | Longword returned on a hit |
| arrWrEn | output | 1 | Write strobe to the cache data array |
| arrWrAddr | output | ADDR_W | Byte address for the array write |
| arrWrData | output | DATA_W | Data for the array write |

## Verification
A stuck or misplaced valid flag shows up at the very next lookup of that longword as a wrong `hitValid` or `hitData`. A recency flag that is wrong, or a miscounted copy, shows up only at the following miss: either as a missing or spurious four-cycle write burst, or as an address or data word that is out of step within that burst. The bench therefore follows every miss with a cycle-by-cycle check of the four cycles after it. It also sweeps all four critical-longword fill orders with full lookup sweeps after every fill.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
  localparam int LINE_WORDS = 4;

  typedef struct packed {
    logic       capMiss;   // latch pending line address
    logic       loadNow;   // open new line directly from the miss
    logic       loadPend;  // open pending line after writeback
    logic       fillEn;    // write fill longword
    logic       wbEn;      // writeback cycle active
    logic [1:0] wbWord;    // longword being copied
    logic       bufUse;    // buffer contents may hit
  } lfbStrobes_t;
endpackage

// File: rtl/lfb_datapath.sv
module lfb_datapath
  import lfb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  lfbStrobes_t         st,
  input  logic [ADDR_W-5:0]   missLine,
  input  logic [1:0]          fillWord,
  input  logic [DATA_W-1:0]   fillData,
  input  logic                lookupValid,
  input  logic [ADDR_W-3:0]   lookupAddr,
  output logic                allValid,
  output logic                idxConflict,
  output logic                hitValid,
  output logic [DATA_W-1:0]   hitData,
  output logic [ADDR_W-1:0]   arrWrAddr,
  output logic [DATA_W-1:0]   arrWrData
);
  localparam int LINE_W = ADDR_W - 4;

  logic [LINE_W-1:0]     lineAddr;
  logic [LINE_W-1:0]     pendLine;
  logic [LINE_WORDS-1:0] valid;
  logic [DATA_W-1:0]     words [LINE_WORDS];

  logic [LINE_W-1:0] lookupLine;
  logic [1:0]        lookupWord;
  logic              lineMatch;

  assign lookupLine  = lookupAddr[ADDR_W-3:2];
  assign lookupWord  = lookupAddr[1:0];
  assign lineMatch   = (lookupLine == lineAddr);
  assign idxConflict = (lookupLine[IDX_W-1:0] == lineAddr[IDX_W-1:0]) && !lineMatch;
  assign allValid    = &valid;

  assign hitValid = lookupValid && st.bufUse && lineMatch && valid[lookupWord];
  assign hitData  = words[lookupWord];

  assign arrWrAddr = {lineAddr, st.wbWord, 2'b00};
  assign arrWrData = st.wbEn ? words[st.wbWord] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineAddr <= '0;
      pendLine <= '0;
      valid    <= '0;
    end else begin
      if (st.capMiss) pendLine <= missLine;
      if (st.loadNow) begin
        lineAddr <= missLine;
        valid    <= '0;
      end else if (st.loadPend) begin
        lineAddr <= pendLine;
        valid    <= '0;
      end else if (st.fillEn) begin
        valid[fillWord] <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < LINE_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (st.fillEn && (fillWord == 2'(i))) words[i] <= fillData;
    end
  end
endmodule

// File: rtl/lfb_ctrl.sv
module lfb_ctrl
  import lfb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        missValid,
  input  logic        missCacheable,
  input  logic        lockFreeze,
  input  logic        bufNcEn,
  input  logic        fillValid,
  input  logic        lookupValid,
  input  logic        allValid,
  input  logic        idxConflict,
  output lfbStrobes_t st,
  output logic        ready
);
  logic       wbActive;
  logic [1:0] wbCnt;
  logic       pendCach, pendUse;
  logic       lineCach, lineUse, mru;

  logic missTake, doWb, lastWb;

  assign missTake = missValid && !wbActive;
  assign doWb     = missTake && allValid && mru && lineCach && !lockFreeze;
  assign lastWb   = wbActive && (wbCnt == 2'd3);
  assign ready    = !wbActive;

  always_comb begin
    st.capMiss  = missTake;
    st.loadNow  = missTake && !doWb;
    st.loadPend = lastWb;
    st.fillEn   = fillValid && !wbActive && !missValid && lineUse;
    st.wbEn     = wbActive;
    st.wbWord   = wbCnt;
    st.bufUse   = lineUse;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbActive <= 1'b0;
      wbCnt    <= 2'd0;
      pendCach <= 1'b0;
      pendUse  <= 1'b0;
      lineCach <= 1'b0;
      lineUse  <= 1'b0;
      mru      <= 1'b0;
    end else begin
      if (doWb) begin
        wbActive <= 1'b1;
        wbCnt    <= 2'd0;
      end else if (wbActive) begin
        wbCnt <= wbCnt + 2'd1;
        if (lastWb) wbActive <= 1'b0;
      end

      if (missTake) begin
        pendCach <= missCacheable;
        pendUse  <= missCacheable || bufNcEn;
      end

      if (st.loadNow) begin
        lineCach <= missCacheable;
        lineUse  <= missCacheable || bufNcEn;
        mru      <= missCacheable;
      end else if (lastWb) begin
        lineCach <= pendCach;
        lineUse  <= pendUse;
        mru      <= pendCach;
      end else if (lookupValid && idxConflict && !wbActive) begin
        mru <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/line_fill_buffer.sv
module line_fill_buffer
  import lfb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [ADDR_W-5:0] missLine,
  input  logic              missCacheable,
  input  logic              lockFreeze,
  input  logic              bufNcEn,
  input  logic              fillValid,
  input  logic [1:0]        fillWord,
  input  logic [DATA_W-1:0] fillData,
  output logic              ready,
  input  logic              lookupValid,
  input  logic [ADDR_W-3:0] lookupAddr,
  output logic              hitValid,
  output logic [DATA_W-1:0] hitData,
  output logic              arrWrEn,
  output logic [ADDR_W-1:0] arrWrAddr,
  output logic [DATA_W-1:0] arrWrData
);
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;

  lfbStrobes_t st;
  logic        allValid, idxConflict;

  lfb_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .missValid    (missValid),
    .missCacheable(missCacheable),
    .lockFreeze   (lockFreeze),
    .bufNcEn      (bufNcEn),
    .fillValid    (fillValid),
    .lookupValid  (lookupValid),
    .allValid     (allValid),
    .idxConflict  (idxConflict),
    .st           (st),
    .ready        (ready)
  );

  lfb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .missLine   (missLine),
    .fillWord   (fillWord),
    .fillData   (fillData),
    .lookupValid(lookupValid),
    .lookupAddr (lookupAddr),
    .allValid   (allValid),
    .idxConflict(idxConflict),
    .hitValid   (hitValid),
    .hitData    (hitData),
    .arrWrAddr  (arrWrAddr),
    .arrWrData  (arrWrData)
  );

  assign arrWrEn = st.wbEn;
endmodule

// File: rtl/line_fill_buffer_chk.sv
module line_fill_buffer_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              missValid,
  input logic              lockFreeze,
  input logic              lookupValid,
  input logic              hitValid,
  input logic              ready,
  input logic              arrWrEn,
  input logic [ADDR_W-3:0] arrWrWordAddr
);
  // R4
  wb_addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (arrWrEn && $past(arrWrEn)) |->
      (arrWrWordAddr[1:0] == $past(arrWrWordAddr[1:0]) + 2'd1) &&
      (arrWrWordAddr[ADDR_W-3:2] == $past(arrWrWordAddr[ADDR_W-3:2])));

  // R4
  wb_first_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(arrWrEn) |-> (arrWrWordAddr[1:0] == 2'd0));

  // R4
  wb_last_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(arrWrEn) |-> ($past(arrWrWordAddr[1:0]) == 2'd3));

  // R9
  wb_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> !ready);

  // R9
  no_unprompted_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !missValid) |=> !arrWrEn);

  // R7
  lock_blocks_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (missValid && ready && lockFreeze) |=> !arrWrEn);

  // R2
  hit_needs_lookup_chk: assert property (@(posedge clk) disable iff (!rstN)
    hitValid |-> lookupValid);
endmodule

bind line_fill_buffer line_fill_buffer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .missValid    (missValid),
  .lockFreeze   (lockFreeze),
  .lookupValid  (lookupValid),
  .hitValid     (hitValid),
  .ready        (ready),
  .arrWrEn      (arrWrEn),
  .arrWrWordAddr(arrWrAddr[ADDR_W-1:2])
);

// File: tb/line_fill_buffer_tb.sv
module line_fill_buffer_tb;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int SETS   = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              missValid = 1'b0;
  logic [ADDR_W-5:0] missLine = '0;
  logic              missCacheable = 1'b0;
  logic              lockFreeze = 1'b0;
  logic              bufNcEn = 1'b0;
  logic              fillValid = 1'b0;
  logic [1:0]        fillWord = '0;
  logic [DATA_W-1:0] fillData = '0;
  logic              ready;
  logic              lookupValid = 1'b0;
  logic [ADDR_W-3:0] lookupAddr = '0;
  logic              hitValid;
  logic [DATA_W-1:0] hitData;
  logic              arrWrEn;
  logic [ADDR_W-1:0] arrWrAddr;
  logic [DATA_W-1:0] arrWrData;

  int nChecks = 0;
  int nFail = 0;

  // reference model state
  int          mLine = 0;
  logic [3:0]  mValid = '0;
  logic [31:0] mData [4];
  logic        mMru = 1'b0, mCach = 1'b0, mUse = 1'b0;

  always #4 clk = ~clk;

  line_fill_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) u_dut (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missLine(missLine),
    .missCacheable(missCacheable), .lockFreeze(lockFreeze), .bufNcEn(bufNcEn),
    .fillValid(fillValid), .fillWord(fillWord), .fillData(fillData), .ready(ready),
    .lookupValid(lookupValid), .lookupAddr(lookupAddr), .hitValid(hitValid),
    .hitData(hitData), .arrWrEn(arrWrEn), .arrWrAddr(arrWrAddr), .arrWrData(arrWrData)
  );

  function automatic logic [31:0] dat(int a, int salt);
    return 32'(a) * 32'h9E3779B1 + 32'h0F1E2D3C + 32'(salt);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic lookup(int addr, string req);
    int  ln = addr >> 4;
    int  w  = (addr >> 2) & 3;
    logic expHit;
    @(negedge clk);
    lookupAddr  = (ADDR_W-2)'(addr >> 2);
    lookupValid = 1'b1;
    expHit = mUse && (ln == mLine) && mValid[w];
    #1;
    chk(req, "hitValid", 32'(hitValid), 32'(expHit));
    if (expHit) chk(req, "hitData", hitData, mData[w]);
    if ((ln != mLine) && ((ln % SETS) == (mLine % SETS))) mMru = 1'b0;
    @(negedge clk);
    lookupValid = 1'b0;
  endtask

  task automatic fill(int w, logic [31:0] d);
    @(negedge clk);
    fillValid = 1'b1;
    fillWord  = 2'(w);
    fillData  = d;
    @(negedge clk);
    fillValid = 1'b0;
    if (mUse) begin
      mValid[w] = 1'b1;
      mData[w]  = d;
    end
  endtask

  task automatic fillLine(int base, int crit, int salt);
    for (int j = 0; j < 4; j++) begin
      int w = (crit + j) & 3;
      fill(w, dat(base + w * 4, salt));
    end
  endtask

  task automatic miss(int addr, logic cach, logic lock, logic nc, string req);
    logic expWb;
    @(negedge clk);
    chk("R9", "ready before miss", 32'(ready), 32'd1);
    missValid     = 1'b1;
    missLine      = (ADDR_W-4)'(addr >> 4);
    missCacheable = cach;
    lockFreeze    = lock;
    bufNcEn       = nc;
    expWb = (&mValid) && mMru && mCach && !lock;
    @(negedge clk);
    missValid  = 1'b0;
    lockFreeze = 1'b0;
    bufNcEn    = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (expWb) begin
        // R9: fill and miss offered while busy must be ignored
        fillValid = 1'b1;
        fillWord  = 2'd0;
        fillData  = 32'hDEAD_BEEF;
        missValid = (k == 1);
        missLine  = (ADDR_W-4)'(addr >> 4) + 1'b1;
        #1;
        chk("R4", "arrWrEn", 32'(arrWrEn), 32'd1);
        chk("R4", "arrWrAddr", 32'(arrWrAddr), 32'((mLine << 4) | (k << 2)));
        chk("R4", "arrWrData", arrWrData, mData[k]);
        chk("R9", "ready during copy", 32'(ready), 32'd0);
      end else begin
        #1;
        chk(req, "arrWrEn", 32'(arrWrEn), 32'd0);
      end
      @(negedge clk);
    end
    fillValid = 1'b0;
    missValid = 1'b0;
    #1;
    chk("R9", "ready after", 32'(ready), 32'd1);
    chk(req, "arrWrEn after", 32'(arrWrEn), 32'd0);
    mLine  = addr >> 4;
    mValid = '0;
    mCach  = cach;
    mUse   = cach || nc;
    mMru   = cach;
    if (expWb) lookup(addr & ~15, "R9");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    // R1: reset state
    lookupValid = 1'b1;
    lookupAddr  = '0;
    repeat (4) @(negedge clk);
    chk("R1", "hitValid in reset", 32'(hitValid), 32'd0);
    chk("R1", "arrWrEn in reset", 32'(arrWrEn), 32'd0);
    chk("R1", "ready in reset", 32'(ready), 32'd1);
    lookupValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "arrWrEn after reset", 32'(arrWrEn), 32'd0);
    lookup(32'h0, "R1");

    // R2/R3/R4: every critical-longword order, full lookup sweep after each fill
    for (int crit = 0; crit < 4; crit++) begin
      int base = (crit * 5 + 1) << 4;
      int prev = mLine << 4;
      miss(base + crit * 4, 1'b1, 1'b0, 1'b0, "R4");
      if (crit > 0) lookup(prev, "R3");
      for (int j = 0; j < 4; j++) begin
        int w = (crit + j) & 3;
        fill(w, dat(base + w * 4, crit));
        for (int q = 0; q < 4; q++) lookup(base + q * 4, "R2");
        lookup(base + 16 + w * 4, "R2");
      end
    end

    // R5: partial line gives no copy
    miss(32'h0400, 1'b1, 1'b0, 1'b0, "R4");
    fill(1, dat(32'h0404, 7));
    fill(2, dat(32'h0408, 7));
    lookup(32'h0404, "R3");
    miss(32'h0500, 1'b1, 1'b0, 1'b0, "R5");

    // R6: conflicting-set lookup clears recency
    fillLine(32'h0500, 2, 8);
    lookup(32'h0500 + 16 * SETS, "R6");
    miss(32'h0610, 1'b1, 1'b0, 1'b0, "R6");
    // R6: same-line lookups keep recency, copy happens
    fillLine(32'h0610, 0, 9);
    lookup(32'h0614, "R6");
    miss(32'h0720, 1'b1, 1'b0, 1'b0, "R6");

    // R7: lock/freeze blocks copy
    fillLine(32'h0720, 3, 10);
    miss(32'h0830, 1'b1, 1'b1, 1'b0, "R7");

    // R8: non-cacheable held in buffer, never copied
    miss(32'h0940, 1'b0, 1'b0, 1'b1, "R8");
    fillLine(32'h0940, 1, 11);
    for (int q = 0; q < 4; q++) lookup(32'h0940 + q * 4, "R8");
    miss(32'h0A50, 1'b0, 1'b0, 1'b0, "R8");
    fill(0, dat(32'h0A50, 12));
    lookup(32'h0A50, "R8");
    miss(32'h0B60, 1'b1, 1'b0, 1'b0, "R8");
    fillLine(32'h0B60, 0, 13);
    miss(32'h0C70, 1'b1, 1'b0, 1'b0, "R4");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule